// File: doc/BRIEF.md
# Time-Sliced Logic Self-Test Controller

This block runs a logic self-test on a processor core in short slices instead of one long pass. The core that is being tested programs the controller itself, through a small register port. Each start command runs one slice. For that slice the controller fences the core off from its interrupt lines. It loads a pseudo-random generator from the seed that belongs to the current slice, clocks stimulus through a stand-in register bank that plays the part of the scanned logic, and folds the bank's responses into a multiple-input signature register.

When the slice ends, the controller compares the signature with the golden value for that slice. It latches done, fail, aborted, wrap and slice-position fields in a status word, and pulses an NMI if the signatures differ. It then holds the core in reset for a fixed number of cycles before it lets the core go. Interrupts that arrive during the slice are kept and handed over on release. An abort input ends the slice at once and skips straight to the core reset. The slice position persists between starts, so successive slices work through the whole seed table and wrap back to the start.

Top module: `lbist_slice_ctrl`

## Requirements
- R1: After reset, busy, core_iso, core_rst, nmi_out and irq_out are 0, and the status word (address 1) reads 0.
- R2: A write of bit 0 = 1 to address 0 while idle starts a slice. The status word at address 1 holds done in bit 0, fail in bit 1, aborted in bit 2, busy in bit 3, full-run wrap in bit 4 and the slice index in bits 15:8.
- R3: A complete slice keeps busy high for SLICE_LEN+3+RST_CYC cycles and core_iso high for SLICE_LEN+2+RST_CYC of them.
- R4: While core_iso is high, irq_out is 0. Any irq_in pulse seen in that time is presented on irq_out in the single release cycle that ends the slice. While idle, irq_in passes straight to irq_out.
- R5: With no fault injected, a slice ends with done=1, fail=0, aborted=0 and no NMI pulse.
- R6: With flt_inj held high, a slice ends with fail=1 and exactly one single-cycle nmi_out pulse.
- R7: Every slice, including failed and aborted ones, ends with core_rst high for exactly RST_CYC consecutive cycles while core_iso is high.
- R8: Each slice that is not aborted moves the slice index up by one, from NSLICE-1 back to 0. The slice that wraps sets the wrap bit, and the next start clears it.
- R9: abort_req during isolation or shifting skips to core reset. It sets done=1, aborted=1 and fail=0, leaves the slice index unchanged and gives no NMI.
- R10: A start write while busy has no effect: the slice length and the index step stay as for a single start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 control, 1 status) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| abort_req | input | 1 | Request to end the running slice early |
| flt_inj | input | 1 | Flips one stimulus bit in the stand-in logic while shifting |
| irq_in | input | NIRQ | Interrupt lines toward the core |
| irq_out | output | NIRQ | Interrupt lines as the core sees them |
| core_iso | output | 1 | Core fenced off from the rest of the system |
| core_rst | output | 1 | Reset to the core |
| nmi_out | output | 1 | NMI pulse on signature mismatch |
| busy | output | 1 | Slice in progress |

## Verification
Counted from the clock edge that accepts the start write, the status word is due SLICE_LEN+2 edges later, and the NMI pulse appears on the same edge. Core reset then covers the next RST_CYC cycles, and busy falls SLICE_LEN+3+RST_CYC edges after the start. The bench drives on falling edges and samples each output on the falling edge after the edge that moves it. It checks cycle lengths by counting samples at falling edges while busy is high, not by reading the FSM. An abort entered in busy cycle a shortens the busy window to a+2+RST_CYC cycles, and the bench derives this length from the requirements.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

   localparam int DW = 32;
   localparam int MAX_REGS = 16;
   localparam logic [DW-1:0] LFSR_POLY = 32'h8020_0003;
   localparam logic [DW-1:0] SEED_STEP = 32'h9E37_79B9;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ISOLATE, ST_SHIFT, ST_COMPARE, ST_RESET, ST_RELEASE
   } seq_state_e;

   function automatic logic [DW-1:0] lfsr_next(input logic [DW-1:0] x);
      return (x >> 1) ^ (x[0] ? LFSR_POLY : '0);
   endfunction

   function automatic logic [DW-1:0] misr_next(input logic [DW-1:0] s,
                                               input logic [DW-1:0] d);
      return lfsr_next(s) ^ d;
   endfunction

   function automatic logic [DW-1:0] stage_mix(input logic [DW-1:0] x,
                                               input int unsigned i);
      return {x[DW-2:0], x[DW-1]} ^ (x >> (i + 1)) ^ DW'(i);
   endfunction

   function automatic logic [DW-1:0] seed_of(input logic [DW-1:0] base,
                                             input int unsigned idx);
      return (base ^ (DW'(idx) * SEED_STEP)) | DW'(1);
   endfunction

   function automatic logic [DW-1:0] golden_sig(input logic [DW-1:0] seed,
                                                input int unsigned len,
                                                input int unsigned nreg);
      logic [DW-1:0] gen;
      logic [DW-1:0] sig;
      logic [DW-1:0] bank [MAX_REGS];
      gen = seed;
      sig = '0;
      for (int k = 0; k < MAX_REGS; k++) bank[k] = '0;
      for (int unsigned c = 0; c < len; c++) begin
         sig = misr_next(sig, bank[nreg-1]);
         for (int unsigned i = nreg - 1; i >= 1; i--) bank[i] = stage_mix(bank[i-1], i);
         bank[0] = stage_mix(gen, 0);
         gen = lfsr_next(gen);
      end
      return sig;
   endfunction

endpackage

// File: rtl/lbist_lfsr.sv
module lbist_lfsr
   import lbist_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] seed,
   input  logic          step,
   output logic [DW-1:0] value
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    value <= DW'(1);
      else if (load) value <= seed;
      else if (step) value <= lfsr_next(value);
   end
endmodule

// File: rtl/lbist_cut.sv
module lbist_cut
   import lbist_pkg::*;
#(
   parameter int NREG = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   input  logic          fault,
   input  logic [DW-1:0] stim,
   output logic [DW-1:0] resp
);
   logic [DW-1:0] bank [NREG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bank[0] <= '0;
      else if (clear) bank[0] <= '0;
      else if (step)  bank[0] <= stage_mix(stim, 0) ^ DW'(fault);
   end

   for (genvar i = 1; i < NREG; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     bank[i] <= '0;
         else if (clear) bank[i] <= '0;
         else if (step)  bank[i] <= stage_mix(bank[i-1], i);
      end
   end

   assign resp = bank[NREG-1];
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr
   import lbist_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] sig
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sig <= '0;
      else if (clear) sig <= '0;
      else if (step)  sig <= misr_next(sig, din);
   end
endmodule

// File: rtl/lbist_slice_ctrl.sv
module lbist_slice_ctrl
   import lbist_pkg::*;
#(
   parameter int            NSLICE    = 8,
   parameter int            SLICE_LEN = 64,
   parameter int            RST_CYC   = 4,
   parameter int            NREG      = 4,
   parameter int            NIRQ      = 4,
   parameter bit            IRQ_HOLD  = 1'b1,
   parameter logic [31:0]   BASE_SEED = 32'hC0DE_1234
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [1:0]      cfg_addr,
   input  logic [31:0]     cfg_wdata,
   output logic [31:0]     cfg_rdata,
   input  logic            abort_req,
   input  logic            flt_inj,
   input  logic [NIRQ-1:0] irq_in,
   output logic [NIRQ-1:0] irq_out,
   output logic            core_iso,
   output logic            core_rst,
   output logic            nmi_out,
   output logic            busy
);
   localparam int IDX_W = (NSLICE > 1) ? $clog2(NSLICE) : 1;
   localparam int CNT_W = $clog2(SLICE_LEN + 1);
   localparam int RCW   = $clog2(RST_CYC + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSLICE - 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SLICE_LEN - 1);
   localparam logic [RCW-1:0]   LAST_RST = RCW'(RST_CYC - 1);

   if (NSLICE < 2 || NSLICE > 256) begin : g_bad_nslice
      $error("NSLICE must be 2..256");
   end
   if (SLICE_LEN < 2) begin : g_bad_len
      $error("SLICE_LEN must be at least 2");
   end
   if (RST_CYC < 1) begin : g_bad_rst
      $error("RST_CYC must be at least 1");
   end
   if (NREG < 1 || NREG > MAX_REGS) begin : g_bad_nreg
      $error("NREG out of range");
   end
   if (NIRQ < 1 || NIRQ > 32) begin : g_bad_nirq
      $error("NIRQ must be 1..32");
   end

   seq_state_e       state;
   logic [CNT_W-1:0] shift_cnt;
   logic [RCW-1:0]   rst_cnt;
   logic [IDX_W-1:0] slice_idx;
   logic             st_done, st_fail, st_abort, st_wrap;
   logic             nmi_q;

   logic [DW-1:0]    seed_tab [NSLICE];
   logic [DW-1:0]    gold_tab [NSLICE];
   for (genvar s = 0; s < NSLICE; s++) begin : g_tab
      localparam logic [DW-1:0] SEED = seed_of(BASE_SEED, s);
      localparam logic [DW-1:0] GOLD = golden_sig(SEED, SLICE_LEN, NREG);
      assign seed_tab[s] = SEED;
      assign gold_tab[s] = GOLD;
   end

   logic start_cmd, abortable, shifting, launch;
   assign start_cmd = cfg_we && (cfg_addr == 2'd0) && cfg_wdata[0];
   assign abortable = (state == ST_ISOLATE) || (state == ST_SHIFT);
   assign shifting  = (state == ST_SHIFT);
   assign launch    = (state == ST_IDLE) && start_cmd;

   logic [DW-1:0] stim, resp, sig;

   lbist_lfsr u_lfsr (
      .clk(clk), .rst_n(rst_n), .load(launch), .seed(seed_tab[slice_idx]),
      .step(shifting), .value(stim)
   );

   lbist_cut #(.NREG(NREG)) u_cut (
      .clk(clk), .rst_n(rst_n), .clear(launch), .step(shifting),
      .fault(flt_inj), .stim(stim), .resp(resp)
   );

   lbist_misr u_misr (
      .clk(clk), .rst_n(rst_n), .clear(launch), .step(shifting),
      .din(resp), .sig(sig)
   );

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         shift_cnt <= '0;
         rst_cnt   <= '0;
      end else begin
         case (state)
            ST_IDLE:    if (start_cmd) state <= ST_ISOLATE;
            ST_ISOLATE: begin
               shift_cnt <= '0;
               rst_cnt   <= '0;
               state     <= abort_req ? ST_RESET : ST_SHIFT;
            end
            ST_SHIFT: begin
               shift_cnt <= shift_cnt + CNT_W'(1);
               if (abort_req)                  state <= ST_RESET;
               else if (shift_cnt == LAST_CNT) state <= ST_COMPARE;
            end
            ST_COMPARE: state <= ST_RESET;
            ST_RESET: begin
               rst_cnt <= rst_cnt + RCW'(1);
               if (rst_cnt == LAST_RST) state <= ST_RELEASE;
            end
            ST_RELEASE: state <= ST_IDLE;
            default:    state <= ST_IDLE;
         endcase
      end
   end

   // status and slice position
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slice_idx <= '0;
         st_done   <= 1'b0;
         st_fail   <= 1'b0;
         st_abort  <= 1'b0;
         st_wrap   <= 1'b0;
         nmi_q     <= 1'b0;
      end else begin
         nmi_q <= 1'b0;
         if (launch) begin
            st_done  <= 1'b0;
            st_fail  <= 1'b0;
            st_abort <= 1'b0;
            st_wrap  <= 1'b0;
         end else if (abortable && abort_req) begin
            st_done  <= 1'b1;
            st_abort <= 1'b1;
         end else if (state == ST_COMPARE) begin
            st_done  <= 1'b1;
            st_fail  <= (sig != gold_tab[slice_idx]);
            nmi_q    <= (sig != gold_tab[slice_idx]);
            st_wrap  <= (slice_idx == LAST_IDX);
            slice_idx <= (slice_idx == LAST_IDX) ? '0 : slice_idx + IDX_W'(1);
         end
      end
   end

   assign busy     = (state != ST_IDLE);
   assign core_iso = busy && (state != ST_RELEASE);
   assign core_rst = (state == ST_RESET);
   assign nmi_out  = nmi_q;

   // interrupt fencing
   if (IRQ_HOLD) begin : g_hold
      logic [NIRQ-1:0] held;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   held <= '0;
         else if (state == ST_RELEASE) held <= '0;
         else if (core_iso)            held <= held | irq_in;
      end
      assign irq_out = core_iso ? '0 : (irq_in | held);
   end else begin : g_drop
      assign irq_out = core_iso ? '0 : irq_in;
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_addr == 2'd1) begin
         cfg_rdata[0]    = st_done;
         cfg_rdata[1]    = st_fail;
         cfg_rdata[2]    = st_abort;
         cfg_rdata[3]    = busy;
         cfg_rdata[4]    = st_wrap;
         cfg_rdata[15:8] = 8'(slice_idx);
      end
   end
endmodule

// File: rtl/lbist_slice_ctrl_chk.sv
module lbist_slice_ctrl_chk
   import lbist_pkg::*;
#(
   parameter int NIRQ = 4
) (
   input logic            clk,
   input logic            rst_n,
   input seq_state_e      state,
   input logic            start_cmd,
   input logic            abort_req,
   input logic            st_fail,
   input logic            core_iso,
   input logic            core_rst,
   input logic            nmi_out,
   input logic [NIRQ-1:0] irq_out
);
   AST_IRQ_FENCED: assert property (@(posedge clk) disable iff (!rst_n)
      core_iso |-> (irq_out == '0));                                    // R4
   AST_RST_UNDER_ISO: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |-> core_iso);                                           // R7
   AST_NMI_MEANS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_out |-> st_fail);                                             // R6
   AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_out |=> !nmi_out);                                            // R6
   AST_ABORT_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_req && (state == ST_ISOLATE || state == ST_SHIFT)) |=> (state == ST_RESET)); // R9
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (start_cmd && state == ST_SHIFT) |=> (state != ST_ISOLATE));      // R10
endmodule

bind lbist_slice_ctrl lbist_slice_ctrl_chk #(.NIRQ(NIRQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .state(state), .start_cmd(start_cmd),
   .abort_req(abort_req), .st_fail(st_fail), .core_iso(core_iso),
   .core_rst(core_rst), .nmi_out(nmi_out), .irq_out(irq_out)
);

// File: tb/tb_lbist_slice_ctrl.sv
module tb_lbist_slice_ctrl;
   localparam int NS = 4, L = 16, RC = 3, NI = 2;

   logic clk = 0, rst_n = 0;
   logic cfg_we = 0, abort_req = 0, flt_inj = 0;
   logic [1:0] cfg_addr = 2'd1;
   logic [31:0] cfg_wdata = '0, cfg_rdata;
   logic [NI-1:0] irq_in = '0, irq_out;
   logic core_iso, core_rst, nmi_out, busy;
   int total = 0, bad = 0, exp_idx = 0;

   always #2.5 clk = ~clk;

   lbist_slice_ctrl #(.NSLICE(NS), .SLICE_LEN(L), .RST_CYC(RC), .NREG(4), .NIRQ(NI)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .abort_req(abort_req),
      .flt_inj(flt_inj), .irq_in(irq_in), .irq_out(irq_out),
      .core_iso(core_iso), .core_rst(core_rst), .nmi_out(nmi_out), .busy(busy)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // abort_at < 0: no abort; restart_at >= 0: extra start write at that busy cycle
   task automatic run_slice(input bit inject, input int abort_at, input int restart_at);
      int nb = 0, ni = 0, nr = 0, nn = 0, leak = 0, rel_irq = 0, first_idx;
      bit wrap_exp;
      first_idx = exp_idx;
      flt_inj = inject;
      @(negedge clk);
      cfg_addr = 2'd0; cfg_wdata = 32'd1; cfg_we = 1;
      @(negedge clk);
      cfg_we = 0; cfg_addr = 2'd1; cfg_wdata = '0;
      while (busy && nb < 500) begin
         irq_in = (nb == 2) ? 2'b10 : 2'b00;
         abort_req = (nb == abort_at);
         if (nb == restart_at) begin cfg_addr = 2'd0; cfg_wdata = 32'd1; cfg_we = 1; end
         else begin cfg_we = 0; cfg_addr = 2'd1; end
         if (core_iso) ni++;
         if (core_rst) nr++;
         if (nmi_out) nn++;
         if (core_iso && irq_out != 0) leak++;
         if (!core_iso && irq_out[1]) rel_irq++;
         nb++;
         @(negedge clk);
      end
      irq_in = '0; abort_req = 0; cfg_we = 0; cfg_addr = 2'd1; flt_inj = 0;
      if (abort_at < 0) begin
         chk("R3 busy cycles", nb, L + 3 + RC);
         chk("R3 iso cycles", ni, L + 2 + RC);
         chk("R5/R6 fail bit", int'(cfg_rdata[1]), int'(inject));
         chk("R5/R6 nmi pulses", nn, inject ? 1 : 0);
         chk("R2 aborted bit", int'(cfg_rdata[2]), 0);
         wrap_exp = (exp_idx == NS - 1);
         exp_idx = (exp_idx + 1) % NS;
         chk("R8 wrap bit", int'(cfg_rdata[4]), int'(wrap_exp));
      end else begin
         chk("R9 busy cycles", nb, abort_at + 2 + RC);
         chk("R9 aborted bit", int'(cfg_rdata[2]), 1);
         chk("R9 fail bit", int'(cfg_rdata[1]), 0);
         chk("R9 no nmi", nn, 0);
      end
      chk("R7 reset cycles", nr, RC);
      chk("R2 done bit", int'(cfg_rdata[0]), 1);
      chk("R2 busy bit", int'(cfg_rdata[3]), 0);
      chk("R8 slice index", int'(cfg_rdata[15:8]), exp_idx);
      chk("R4 irq fenced", leak, 0);
      chk("R4 irq released", rel_irq, 1);
      chk("R4 irq cleared", int'(irq_out), 0);
      if (restart_at >= 0) chk("R10 single step", (exp_idx - first_idx + NS) % NS, 1);
   endtask

   initial begin
      #1000000;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 busy", int'(busy), 0);
      chk("R1 status", int'(cfg_rdata), 0);
      chk("R1 outputs", int'({core_iso, core_rst, nmi_out}), 0);
      chk("R1 irq_out", int'(irq_out), 0);
      rst_n = 1;
      @(negedge clk);
      irq_in = 2'b01;
      #0.1;
      chk("R4 idle passthrough", int'(irq_out), 1);
      irq_in = '0;
      for (int k = 0; k < NS + 2; k++) run_slice(1'b0, -1, -1);   // R8 sweep with wrap
      run_slice(1'b1, -1, -1);                                    // R6
      run_slice(1'b0, -1, -1);                                    // R5 after a fail
      for (int a = 0; a <= L; a += 5) run_slice(1'b0, a, -1);     // R9
      run_slice(1'b0, -1, 1);                                     // R10
      run_slice(1'b0, -1, L);                                     // R10
      run_slice(1'b1, 4, -1);                                     // R9 with fault
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule